// File: doc/BRIEF.md
# Tri-Channel Sample Sequencer

This block controls sampling and channel selection for a three-channel image front end. It runs on a system clock that is much faster than the external strobes. It brings in four asynchronous strobes and detects their edges: the reference-sample strobe, the data-sample strobe, the clamp request and the converter clock. From those edges it produces registered sample pulses, a clamp enable, a two-bit channel select for the converter multiplexer, and a conversion-start pulse that carries the channel tag of that conversion.

Four configuration inputs set the behaviour:
- A sensor-type bit chooses between correlated double sampling and single-sample contact-sensor operation.
- A single-channel bit freezes the multiplexer on one coded channel.
- A two-bit code selects that channel.
- A direction bit reverses the rotation order.

A falling edge of the reference strobe restarts the rotation at the first channel of the selected order. The rotation then advances on a later edge: the data strobe in correlated mode, or the converter clock in contact-sensor mode. This gives three conversions per pixel. The block also keeps a sticky flag that records one timing fault: a data-strobe fall that lands in the high phase of the converter clock in three-channel correlated mode.

Top module: `tcs_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, the channel select is 00 and every pulse output, the clamp enable and the fault flag are 0.
- R2: Channel codes are 00 red, 01 green, 10 blue. In three-channel mode a reference-strobe fall loads red when the direction bit is 0 and blue when it is 1.
- R3: In three-channel correlated mode each data-strobe fall steps the select. The forward order is 00→01→10→00 and the reverse order is 10→01→00→10. Converter-clock edges do not move the select in this mode.
- R4: In three-channel contact-sensor mode each converter-clock fall steps the select in the same orders as R3. Stepping starts only after the first reference-strobe fall since reset. Data-strobe edges are ignored in this mode.
- R5: In single-channel mode the select equals the channel code, with code 11 mapped to 10, and strobe edges do not change it.
- R6: In correlated mode the reference sample pulse fires on a reference-strobe fall and the data sample pulse fires on a data-strobe fall. If both strobes fall in the same cycle, only the reference pulse fires. The two sample pulses are never high together.
- R7: In contact-sensor mode only the data sample pulse fires, and it fires on a reference-strobe fall. A data-strobe fall produces no pulse.
- R8: The clamp enable is 1 only when the clamp request and the reference strobe are both high in correlated mode. It is 0 in contact-sensor mode.
- R9: Each rising edge of the converter clock gives a one-cycle conversion-start pulse. The pulse carries a tag equal to the select value held at that moment. Neither the tag nor the select is ever 11.
- R10: The fault flag sets when a data-strobe fall occurs while the converter clock is high in three-channel correlated mode. Once set, it stays set until reset.
- R11: Every output pulse lasts one cycle. It appears SYNC_STAGES+1 clock cycles after the input transition that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sensor | input | 1 | 0 correlated sampling, 1 contact-sensor single sample |
| cfg_single | input | 1 | 1 holds the multiplexer on one channel |
| cfg_chan | input | 2 | Channel code for single-channel mode |
| cfg_rev | input | 1 | 0 forward order, 1 reverse order |
| ref_strobe | input | 1 | Reference-sample strobe, asynchronous |
| dat_strobe | input | 1 | Data-sample strobe, asynchronous |
| clamp_req | input | 1 | Clamp request, asynchronous |
| conv_clk | input | 1 | Converter clock, asynchronous |
| samp_ref | output | 1 | Reference-level sample pulse |
| samp_dat | output | 1 | Data-level sample pulse |
| clamp_en | output | 1 | Input clamp enable |
| mux_sel | output | 2 | Converter multiplexer channel select |
| conv_start | output | 1 | Conversion-start pulse |
| conv_tag | output | 2 | Channel tag that goes with conv_start |
| timing_err | output | 1 | Sticky fault flag for a late data strobe |

## Verification
A wrong channel register shows up directly on mux_sel once the strobe edge that should have moved it has passed through the synchronizer. The same fault appears on conv_tag at the next converter-clock rise, so a misordered rotation is visible within one strobe period. An armed flag that is lost or set too early shows up when the select fails to step, or steps, on a converter-clock fall before the reference-strobe fall. A synchronizer of the wrong depth moves every pulse by a cycle. The bench therefore checks one pulse at the exact cycle count it expects.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [1:0] {
    CH_RED   = 2'b00,
    CH_GREEN = 2'b01,
    CH_BLUE  = 2'b10
  } chan_t;

  // first channel of a rotation
  function automatic chan_t chan_first(input logic rev);
    return rev ? CH_BLUE : CH_RED;
  endfunction

  // next channel in the selected direction, wrapping
  function automatic chan_t chan_step(input chan_t cur, input logic rev);
    chan_t nxt;
    if (!rev) begin
      case (cur)
        CH_RED:   nxt = CH_GREEN;
        CH_GREEN: nxt = CH_BLUE;
        default:  nxt = CH_RED;
      endcase
    end else begin
      case (cur)
        CH_BLUE:  nxt = CH_GREEN;
        CH_GREEN: nxt = CH_RED;
        default:  nxt = CH_BLUE;
      endcase
    end
    return nxt;
  endfunction

  // fixed channel code, the unused code folds onto blue
  function automatic chan_t chan_fix(input logic [1:0] code);
    chan_t c;
    case (code)
      2'b00:   c = CH_RED;
      2'b01:   c = CH_GREEN;
      default: c = CH_BLUE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tcs_edge_sync.sv
module tcs_edge_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] stg [STAGES];
  logic [WIDTH-1:0] last;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      last <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      last <= stg[STAGES-1];
    end
  end

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~last;
  assign fall = ~lvl & last;

endmodule

// File: rtl/tcs_chan_ctrl.sv
module tcs_chan_ctrl
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sensor,
  input  logic       cfg_single,
  input  logic [1:0] cfg_chan,
  input  logic       cfg_rev,
  input  logic       ref_fall,
  input  logic       dat_fall,
  input  logic       cv_fall,
  output chan_t      sel_q
);

  logic armed;
  logic step;

  // stepping edge depends on the sampling style
  assign step = cfg_sensor ? (armed && cv_fall) : dat_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= CH_RED;
      armed <= 1'b0;
    end else begin
      if (ref_fall) armed <= 1'b1;
      if (cfg_single)
        sel_q <= chan_fix(cfg_chan);
      else if (ref_fall)
        sel_q <= chan_first(cfg_rev);
      else if (step)
        sel_q <= chan_step(sel_q, cfg_rev);
    end
  end

endmodule

// File: rtl/tcs_pulse_gen.sv
module tcs_pulse_gen
  import tcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sensor,
  input  logic       cfg_single,
  input  logic       ref_fall,
  input  logic       ref_lvl,
  input  logic       dat_fall,
  input  logic       clp_lvl,
  input  logic       cv_rise,
  input  logic       cv_lvl,
  input  chan_t      sel_q,
  output logic       samp_ref,
  output logic       samp_dat,
  output logic       clamp_en,
  output logic       conv_start,
  output logic [1:0] conv_tag,
  output logic       timing_err
);

  logic late_dat;
  assign late_dat = !cfg_sensor && !cfg_single && dat_fall && cv_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_ref   <= 1'b0;
      samp_dat   <= 1'b0;
      clamp_en   <= 1'b0;
      conv_start <= 1'b0;
      conv_tag   <= 2'b00;
      timing_err <= 1'b0;
    end else begin
      samp_ref   <= !cfg_sensor && ref_fall;
      samp_dat   <= cfg_sensor ? ref_fall : (dat_fall && !ref_fall);
      clamp_en   <= !cfg_sensor && clp_lvl && ref_lvl;
      conv_start <= cv_rise;
      if (cv_rise) conv_tag <= sel_q;
      timing_err <= timing_err || late_dat;
    end
  end

endmodule

// File: rtl/tcs_seq.sv
module tcs_seq
  import tcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_sensor,
  input  logic       cfg_single,
  input  logic [1:0] cfg_chan,
  input  logic       cfg_rev,
  input  logic       ref_strobe,
  input  logic       dat_strobe,
  input  logic       clamp_req,
  input  logic       conv_clk,
  output logic       samp_ref,
  output logic       samp_dat,
  output logic       clamp_en,
  output logic [1:0] mux_sel,
  output logic       conv_start,
  output logic [1:0] conv_tag,
  output logic       timing_err
);

  localparam int NSIG  = 4;
  localparam int I_REF = 0;
  localparam int I_DAT = 1;
  localparam int I_CLP = 2;
  localparam int I_CV  = 3;

  logic [NSIG-1:0] raw, lvl, rise, fall;
  chan_t sel_q;

  assign raw[I_REF] = ref_strobe;
  assign raw[I_DAT] = dat_strobe;
  assign raw[I_CLP] = clamp_req;
  assign raw[I_CV]  = conv_clk;

  tcs_edge_sync #(.STAGES(SYNC_STAGES), .WIDTH(NSIG)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .lvl (lvl),
    .rise(rise),
    .fall(fall)
  );

  tcs_chan_ctrl u_chan (
    .clk       (clk),
    .rst       (rst),
    .cfg_sensor(cfg_sensor),
    .cfg_single(cfg_single),
    .cfg_chan  (cfg_chan),
    .cfg_rev   (cfg_rev),
    .ref_fall  (fall[I_REF]),
    .dat_fall  (fall[I_DAT]),
    .cv_fall   (fall[I_CV]),
    .sel_q     (sel_q)
  );

  tcs_pulse_gen u_pulse (
    .clk       (clk),
    .rst       (rst),
    .cfg_sensor(cfg_sensor),
    .cfg_single(cfg_single),
    .ref_fall  (fall[I_REF]),
    .ref_lvl   (lvl[I_REF]),
    .dat_fall  (fall[I_DAT]),
    .clp_lvl   (lvl[I_CLP]),
    .cv_rise   (rise[I_CV]),
    .cv_lvl    (lvl[I_CV]),
    .sel_q     (sel_q),
    .samp_ref  (samp_ref),
    .samp_dat  (samp_dat),
    .clamp_en  (clamp_en),
    .conv_start(conv_start),
    .conv_tag  (conv_tag),
    .timing_err(timing_err)
  );

  assign mux_sel = sel_q;

endmodule

// File: rtl/tcs_seq_chk.sv
module tcs_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_sensor,
  input logic       cfg_single,
  input logic [1:0] cfg_chan,
  input logic       samp_ref,
  input logic       samp_dat,
  input logic       clamp_en,
  input logic [1:0] mux_sel,
  input logic       conv_start,
  input logic [1:0] conv_tag,
  input logic       timing_err
);

  // R1: clean state out of reset
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mux_sel == 2'b00 && !samp_ref && !samp_dat && !clamp_en &&
             !conv_start && !timing_err));

  // R6: sample pulses never overlap
  a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({samp_ref, samp_dat}));

  // R7: no reference pulse in contact-sensor mode
  a_r7_no_ref: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_sensor) |-> !samp_ref);

  // R8: no clamp in contact-sensor mode
  a_r8_no_clamp: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_sensor) |-> !clamp_en);

  // R9: tag and select stay in the legal code set
  a_r9_tag_legal: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> conv_tag != 2'b11);
  a_r9_sel_legal: assert property (@(posedge clk) disable iff (rst)
    mux_sel != 2'b11);

  // R5: select follows a steady channel code
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    (cfg_single && $past(cfg_single) && $stable(cfg_chan)) |->
      mux_sel == ((cfg_chan == 2'b11) ? 2'b10 : cfg_chan));

  // R10: fault flag is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    timing_err |=> timing_err);

  // R11: one-cycle pulses
  a_r11_ref_width: assert property (@(posedge clk) disable iff (rst)
    samp_ref |=> !samp_ref);
  a_r11_start_width: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

endmodule

bind tcs_seq tcs_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_sensor(cfg_sensor),
  .cfg_single(cfg_single),
  .cfg_chan  (cfg_chan),
  .samp_ref  (samp_ref),
  .samp_dat  (samp_dat),
  .clamp_en  (clamp_en),
  .mux_sel   (mux_sel),
  .conv_start(conv_start),
  .conv_tag  (conv_tag),
  .timing_err(timing_err)
);

// File: tb/tcs_seq_bench.sv
`timescale 1ns/1ps
module tcs_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_sensor = 1'b0, cfg_single = 1'b0, cfg_rev = 1'b0;
  logic [1:0] cfg_chan = 2'b00;
  logic       ref_strobe = 1'b0, dat_strobe = 1'b0, clamp_req = 1'b0, conv_clk = 1'b0;
  logic       samp_ref, samp_dat, clamp_en, conv_start, timing_err;
  logic [1:0] mux_sel, conv_tag;

  int checks = 0;
  int errors = 0;
  int ref_cnt = 0, dat_cnt = 0, start_cnt = 0;
  logic [1:0] last_tag = 2'b00;
  bit done = 0;

  always #2.5 clk = ~clk;

  tcs_seq u_tcs_seq (
    .clk(clk), .rst(rst), .cfg_sensor(cfg_sensor), .cfg_single(cfg_single),
    .cfg_chan(cfg_chan), .cfg_rev(cfg_rev), .ref_strobe(ref_strobe),
    .dat_strobe(dat_strobe), .clamp_req(clamp_req), .conv_clk(conv_clk),
    .samp_ref(samp_ref), .samp_dat(samp_dat), .clamp_en(clamp_en),
    .mux_sel(mux_sel), .conv_start(conv_start), .conv_tag(conv_tag),
    .timing_err(timing_err)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (samp_ref) ref_cnt++;
      if (samp_dat) dat_cnt++;
      if (conv_start) begin start_cnt++; last_tag = conv_tag; end
    end
  end

  // {sensor, single, chan[1:0], rev, action[1:0], expected select[1:0]}
  // action 00 reference strobe, 01 data strobe, 10 converter clock
  localparam int NVEC = 20;
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_0_00_0_00_00, 9'b0_0_00_0_01_01, 9'b0_0_00_0_01_10, 9'b0_0_00_0_01_00,
    9'b0_0_00_0_00_00, 9'b0_0_00_0_10_00, 9'b0_0_00_1_00_10, 9'b0_0_00_1_01_01,
    9'b0_0_00_1_01_00, 9'b1_0_00_0_00_00, 9'b1_0_00_0_10_01, 9'b1_0_00_0_10_10,
    9'b1_0_00_0_01_10, 9'b1_0_00_0_10_00, 9'b1_0_00_1_00_10, 9'b1_0_00_1_10_01,
    9'b0_1_01_0_00_01, 9'b0_1_01_0_01_01, 9'b0_1_11_0_00_10, 9'b1_1_10_1_10_10
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ref_strobe = 0; dat_strobe = 0; clamp_req = 0; conv_clk = 0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ref_strobe = 1'b1;
      1: dat_strobe = 1'b1;
      default: conv_clk = 1'b1;
    endcase
    wait_cyc(4);
    case (which)
      0: ref_strobe = 1'b0;
      1: dat_strobe = 1'b0;
      default: conv_clk = 1'b0;
    endcase
    wait_cyc(5);
  endtask

  task automatic set_cfg(input logic s, input logic g, input logic [1:0] c, input logic r);
    @(negedge clk);
    cfg_sensor = s; cfg_single = g; cfg_chan = c; cfg_rev = r;
    wait_cyc(4);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 sel", mux_sel, 0);
    check("R1 pulses", {samp_ref, samp_dat, conv_start, clamp_en}, 0);
    check("R1 err", timing_err, 0);

    // table walk: R2, R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      logic [8:0] v;
      string tag;
      v = VEC[i];
      set_cfg(v[8], v[7], v[6:5], v[4]);
      pulse(int'(v[3:2]));
      tag = v[7] ? "R5" : (v[8] ? "R4" : (v[3:2] == 2'b00 ? "R2" : "R3"));
      check($sformatf("%s vec %0d", tag, i), mux_sel, int'(v[1:0]));
    end
    check("R10 no fault from table", timing_err, 0);

    // R11: exact latency of a reference pulse
    set_cfg(0, 0, 2'b00, 0);
    @(negedge clk) ref_strobe = 1'b1;
    wait_cyc(4);
    ref_strobe = 1'b0;
    @(negedge clk) check("R11 cyc1", samp_ref, 0);
    @(negedge clk) check("R11 cyc2", samp_ref, 0);
    @(negedge clk) check("R11 cyc3", samp_ref, 1);
    @(negedge clk) check("R11 cyc4", samp_ref, 0);
    wait_cyc(3);

    // R6: correlated-mode pulses
    begin
      int r0, d0;
      r0 = ref_cnt; d0 = dat_cnt;
      pulse(0);
      check("R6 ref on ref fall", ref_cnt - r0, 1);
      check("R6 no dat on ref fall", dat_cnt - d0, 0);
      r0 = ref_cnt; d0 = dat_cnt;
      pulse(1);
      check("R6 dat on dat fall", dat_cnt - d0, 1);
      check("R6 no ref on dat fall", ref_cnt - r0, 0);
      r0 = ref_cnt; d0 = dat_cnt;
      @(negedge clk) begin ref_strobe = 1; dat_strobe = 1; end
      wait_cyc(4);
      ref_strobe = 0; dat_strobe = 0;
      wait_cyc(5);
      check("R6 joint fall ref", ref_cnt - r0, 1);
      check("R6 joint fall dat", dat_cnt - d0, 0);
    end

    // R7: contact-sensor pulses
    set_cfg(1, 0, 2'b00, 0);
    begin
      int r0, d0;
      r0 = ref_cnt; d0 = dat_cnt;
      pulse(0);
      check("R7 dat on ref fall", dat_cnt - d0, 1);
      check("R7 no ref", ref_cnt - r0, 0);
      d0 = dat_cnt;
      pulse(1);
      check("R7 dat strobe ignored", dat_cnt - d0, 0);
    end

    // R8: clamp
    set_cfg(0, 0, 2'b00, 0);
    @(negedge clk) begin clamp_req = 1; ref_strobe = 1; end
    wait_cyc(5);
    check("R8 clamp on", clamp_en, 1);
    clamp_req = 0;
    wait_cyc(5);
    check("R8 clamp off req low", clamp_en, 0);
    clamp_req = 1; ref_strobe = 0;
    wait_cyc(5);
    check("R8 clamp off strobe low", clamp_en, 0);
    clamp_req = 0;
    set_cfg(1, 0, 2'b00, 0);
    clamp_req = 1; ref_strobe = 1;
    wait_cyc(5);
    check("R8 clamp off sensor", clamp_en, 0);
    clamp_req = 0; ref_strobe = 0;
    wait_cyc(5);

    // R9: tags follow the rotation
    begin
      int s0;
      pulse(0);
      s0 = start_cnt;
      pulse(2); check("R9 tag red", last_tag, 0);
      pulse(2); check("R9 tag green", last_tag, 1);
      pulse(2); check("R9 tag blue", last_tag, 2);
      check("R9 start count", start_cnt - s0, 3);
    end

    // R4: no stepping before the first reference fall
    do_reset();
    set_cfg(1, 0, 2'b00, 0);
    pulse(2);
    check("R4 unarmed hold", mux_sel, 0);
    pulse(0);
    pulse(2);
    check("R4 armed step", mux_sel, 1);

    // R10: fault flag
    do_reset();
    set_cfg(0, 1, 2'b00, 0);
    @(negedge clk) conv_clk = 1;
    wait_cyc(4);
    pulse(1);
    check("R10 single mode no fault", timing_err, 0);
    set_cfg(0, 0, 2'b00, 0);
    pulse(1);
    check("R10 fault set", timing_err, 1);
    @(negedge clk) conv_clk = 0;
    wait_cyc(4);
    pulse(0);
    check("R10 fault sticky", timing_err, 1);
    do_reset();
    check("R10 fault cleared by reset", timing_err, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule